// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol engine on the slave side of a two-wire serial memory. It samples the bus clock and data lines with the system clock, finds Start and Stop conditions, and decodes the control byte and the two word-address bytes. It acknowledges a transfer only when the type code and the strap-selected device number match. It drives the data line through an active-high pull-down enable, so the pad stays open-drain.

Write data goes out on a cache port, one strobe per accepted byte, together with the address of that byte. A Stop that closes a write which carried data raises a one-cycle request for an internal write cycle. While the array side reports that a write cycle is running, the controller stays silent on the bus. A master can therefore poll for completion with repeated write control bytes. Reads fetch bytes through a combinational read port addressed by the internal pointer. The block supports current-address, random and sequential reads.

Top module: `eeprom_slave_ctrl`

## Requirements
- R1: A falling data line while the clock is high is a Start, and a rising data line while the clock is high is a Stop. Either one, seen in any state and even part way through a byte, drops the transaction in progress. It clears the bit count and releases the data line. After a Start the next byte is decoded as a control byte.
- R2: A control byte is accepted only if bits 7..4 equal 1010 and bits 3..1 equal `sel_i`. An accepted control byte is acknowledged by holding `sda_oe_o` high for the ninth clock. A control byte that does not match gets no acknowledge, and the bus is ignored until the next Start.
- R3: Bit 0 of the control byte selects the direction: 1 reads and 0 writes. After a read control byte the slave transmits data, and after a write control byte it expects the address.
- R4: On a write, two address bytes follow, high byte first and MSB first. Each is acknowledged. The pointer is loaded with the low ADDR_W bits (12 by default) when the low byte completes, and address bits above ADDR_W are ignored.
- R5: Each write data byte is acknowledged and presented on the cache port with a one-cycle `cache_we_o`, the current pointer as address, and the byte as data. Afterwards the pointer increments only in its low BURST_W bits (6 by default), so a long burst wraps inside its 64-byte window and overwrites earlier bytes.
- R6: A Stop ends a write that accepted at least one data byte and raises `wcyc_start_o` for exactly one cycle. None is raised by a Stop after an address-only write, by a Stop after a read, or when a repeated Start aborts a write.
- R7: While `wcyc_busy_i` is high, no control byte is acknowledged, whether it is a read or a write.
- R8: A current-address read returns the byte at the pointer, which is the last accessed address plus one.
- R9: A random read is a write of the word address alone, then a repeated Start and a read control byte. It returns the byte at that address.
- R10: In a read, a master acknowledge after a byte makes the slave send the byte at the next address. The read pointer increments over its full width and wraps from the top address to 0.
- R11: After a master no-acknowledge the slave releases the data line and ignores further clocks until a Start or Stop.
- R12: `sda_oe_o` changes only while the sampled clock is low. The line the slave drives is stable through every clock-high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| sel_i | input | 3 | Strap-pin device number |
| wcyc_busy_i | input | 1 | Internal write cycle running |
| wcyc_start_o | output | 1 | One-cycle request to start the write cycle |
| rd_addr_o | output | ADDR_W | Read port address, equal to the pointer |
| rd_data_i | input | 8 | Read port data for `rd_addr_o` |
| cache_we_o | output | 1 | Cache byte write strobe |
| cache_addr_o | output | ADDR_W | Cache byte address |
| cache_data_o | output | 8 | Cache byte data |

## Verification
The hardest case to reach is the busy window. The write-cycle request has to arrive while a master keeps addressing the device, and each control byte must be refused until the array side drops busy. The bench models the array's busy timer from `wcyc_start_o` and starts polling right after the Stop. It checks that the first polls get no acknowledge and that a later one does. Bus aborts part way through a byte, the 64-byte write wrap and the read pointer wrapping at the top address are driven directly. Seeded random bursts then write and read back arbitrary windows.

// File: rtl/eeprom_slv_pkg.sv
package eeprom_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } state_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/eeprom_bus_sampler.sv
module eeprom_bus_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;

  // bus idles high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_o;
      sda_q    <= sda_o;
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned BURST_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_burst_i,
  input  logic              inc_full_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q, burst_nxt, full_nxt;

  assign full_nxt = ptr_q + ADDR_W'(1);

  generate
    if (BURST_W >= ADDR_W) begin : g_flat
      assign burst_nxt = full_nxt;
    end else begin : g_win
      logic [BURST_W-1:0] low_nxt;
      assign low_nxt   = ptr_q[BURST_W-1:0] + BURST_W'(1);
      assign burst_nxt = {ptr_q[ADDR_W-1:BURST_W], low_nxt};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (load_i)      ptr_q <= load_val_i;
    else if (inc_burst_i) ptr_q <= burst_nxt;
    else if (inc_full_i)  ptr_q <= full_nxt;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/eeprom_slave_ctrl.sv
module eeprom_slave_ctrl
  import eeprom_slv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned BURST_W     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [2:0]        sel_i,
  input  logic              wcyc_busy_i,
  output logic              wcyc_start_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              cache_we_o,
  output logic [ADDR_W-1:0] cache_addr_o,
  output logic [7:0]        cache_data_o
);
  localparam int unsigned HI_W = ADDR_W - 8;
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eeprom_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  state_e            state_q;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sh, tx_sh;
  logic [HI_W-1:0]   hi_q;
  logic              rw_q, mack_q, wr_dirty, sda_oe_q;
  logic              cache_we_q, wcyc_q;
  logic [ADDR_W-1:0] cache_addr_q, ptr;
  logic [7:0]        cache_data_q;
  logic              byte_done, ctrl_match;
  logic [2:0]        tx_idx;

  assign byte_done  = scl_fall && (bit_cnt == LAST_BIT) && (state_q != ST_IDLE);
  assign ctrl_match = (rx_sh[7:4] == TYPE_CODE) && (rx_sh[3:1] == sel_i) && !wcyc_busy_i;
  assign tx_idx     = 3'd7 - bit_cnt[2:0];

  eeprom_addr_ptr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (byte_done && state_q == ST_ALO),
    .load_val_i  ({hi_q, rx_sh}),
    .inc_burst_i (byte_done && state_q == ST_WDATA),
    .inc_full_i  (byte_done && state_q == ST_RDATA),
    .ptr_o       (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      bit_cnt      <= '0;
      rx_sh        <= '0;
      tx_sh        <= '0;
      hi_q         <= '0;
      rw_q         <= 1'b0;
      mack_q       <= 1'b0;
      wr_dirty     <= 1'b0;
      sda_oe_q     <= 1'b0;
      cache_we_q   <= 1'b0;
      cache_addr_q <= '0;
      cache_data_q <= '0;
      wcyc_q       <= 1'b0;
    end else begin
      cache_we_q <= 1'b0;
      wcyc_q     <= 1'b0;
      if (start_det) begin
        state_q  <= ST_CTRL;
        bit_cnt  <= '0;
        sda_oe_q <= 1'b0;
        wr_dirty <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        bit_cnt  <= '0;
        sda_oe_q <= 1'b0;
        wr_dirty <= 1'b0;
        wcyc_q   <= wr_dirty;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt < LAST_BIT) rx_sh <= {rx_sh[6:0], sda_s};
          else if (bit_cnt == LAST_BIT) mack_q <= ~sda_s;
          if (bit_cnt < ACK_BIT) bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall) begin
          if (bit_cnt == LAST_BIT) begin
            // byte complete: open the acknowledge slot
            unique case (state_q)
              ST_CTRL: begin
                if (ctrl_match) begin
                  sda_oe_q <= 1'b1;
                  rw_q     <= rx_sh[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                sda_oe_q <= 1'b1;
                hi_q     <= rx_sh[HI_W-1:0];
              end
              ST_ALO: sda_oe_q <= 1'b1;
              ST_WDATA: begin
                sda_oe_q     <= 1'b1;
                cache_we_q   <= 1'b1;
                cache_addr_q <= ptr;
                cache_data_q <= rx_sh;
                wr_dirty     <= 1'b1;
              end
              default: sda_oe_q <= 1'b0;
            endcase
          end else if (bit_cnt == ACK_BIT) begin
            bit_cnt <= '0;
            unique case (state_q)
              ST_CTRL: begin
                if (rw_q) begin
                  state_q  <= ST_RDATA;
                  tx_sh    <= rd_data_i;
                  sda_oe_q <= ~rd_data_i[7];
                end else begin
                  state_q  <= ST_AHI;
                  sda_oe_q <= 1'b0;
                end
              end
              ST_AHI: begin
                state_q  <= ST_ALO;
                sda_oe_q <= 1'b0;
              end
              ST_ALO: begin
                state_q  <= ST_WDATA;
                sda_oe_q <= 1'b0;
              end
              ST_RDATA: begin
                if (mack_q) begin
                  tx_sh    <= rd_data_i;
                  sda_oe_q <= ~rd_data_i[7];
                end else begin
                  state_q  <= ST_IDLE;
                  sda_oe_q <= 1'b0;
                end
              end
              default: sda_oe_q <= 1'b0;
            endcase
          end else if (state_q == ST_RDATA) begin
            sda_oe_q <= ~tx_sh[tx_idx];
          end
        end
      end
    end
  end

  assign sda_oe_o     = sda_oe_q;
  assign wcyc_start_o = wcyc_q;
  assign rd_addr_o    = ptr;
  assign cache_we_o   = cache_we_q;
  assign cache_addr_o = cache_addr_q;
  assign cache_data_o = cache_data_q;
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk
  import eeprom_slv_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   sda_oe_i,
  input logic   scl_s_i,
  input logic   stop_i,
  input logic   wcyc_start_i,
  input logic   cache_we_i,
  input logic   busy_i,
  input state_e state_i
);
  AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i); // R12

  AST_WCYC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcyc_start_i |=> !wcyc_start_i); // R6

  AST_WCYC_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcyc_start_i |-> $past(stop_i)); // R6

  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_i) && state_i == ST_CTRL) |-> !$past(busy_i)); // R7

  AST_WRITE_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_we_i |-> sda_oe_i); // R5
endmodule

bind eeprom_slave_ctrl eeprom_slave_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sda_oe_i     (sda_oe_o),
  .scl_s_i      (scl_s),
  .stop_i       (stop_det),
  .wcyc_start_i (wcyc_start_o),
  .cache_we_i   (cache_we_o),
  .busy_i       (wcyc_busy_i),
  .state_i      (state_q)
);

// File: tb/eeprom_slave_ctrl_bench.sv
module eeprom_slave_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int BUSY_CYC   = 1000;
  localparam int MEM_N      = 4096;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, wcyc_start, cache_we, busy;
  logic [11:0] rd_addr, cache_addr;
  logic [7:0] rd_data, cache_data;
  wire sda_bus = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_slave_ctrl u_eeprom_slave_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .sel_i(SEL), .wcyc_busy_i(busy),
    .wcyc_start_o(wcyc_start), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .cache_we_o(cache_we), .cache_addr_o(cache_addr), .cache_data_o(cache_data)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  logic [7:0] dut_mem [MEM_N];
  logic [7:0] ref_mem [MEM_N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) dut_mem[i] <= init_val(i);
    end else if (cache_we) begin
      dut_mem[cache_addr] <= cache_data;
    end
  end
  assign rd_data = dut_mem[rd_addr];

  int busy_cnt;
  int wc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= 0;
      wc <= 0;
    end else begin
      if (wcyc_start) begin
        busy_cnt <= BUSY_CYC;
        wc <= wc + 1;
      end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    end
  end
  assign busy = (busy_cnt != 0);

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [11:0] ref_ptr;
  logic [7:0] wbuf [80];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cw(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl(input bit rd);
    return {4'b1010, SEL, rd};
  endfunction

  function automatic logic [11:0] burst_inc(input logic [11:0] a);
    return {a[11:6], 6'(a[5:0] + 6'd1)};
  endfunction

  task automatic bus_start();
    if (m_scl == 1'b0) begin
      cw(2); m_sda = 1'b1; cw(HALF); m_scl = 1'b1; cw(HALF);
    end
    m_sda = 1'b0; cw(HALF); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    cw(2); m_sda = 1'b0; cw(HALF); m_scl = 1'b1; cw(HALF); m_sda = 1'b1; cw(HALF);
  endtask

  task automatic send_bit(input bit b);
    cw(2); m_sda = b; cw(HALF); m_scl = 1'b1; cw(HALF); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    cw(2); m_sda = 1'b1; cw(HALF); m_scl = 1'b1; cw(HALF/2);
    ack = !sda_bus;
    cw(HALF/2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit s1, s2, stab;
    stab = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cw(2); m_sda = 1'b1; cw(HALF); m_scl = 1'b1; cw(HALF/2);
      s1 = sda_bus; cw(HALF/2); s2 = sda_bus;
      stab &= (s1 == s2);
      d[i] = s1;
      m_scl = 1'b0;
    end
    chk(stab, "R12 slave data stable while clock high", int'(stab), 1);
    cw(2); m_sda = !mack; cw(HALF); m_scl = 1'b1; cw(HALF); m_scl = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a16, input int n, output bit all_ack);
    bit ack;
    logic [11:0] p;
    all_ack = 1'b1;
    bus_start();
    send_byte(ctrl(1'b0), ack); all_ack &= ack;
    send_byte(a16[15:8], ack);  all_ack &= ack;
    send_byte(a16[7:0], ack);   all_ack &= ack;
    p = a16[11:0];
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); all_ack &= ack;
      ref_mem[p] = wbuf[i];
      p = burst_inc(p);
    end
    bus_stop();
    ref_ptr = p;
  endtask

  task automatic poll_ready(output int polls);
    bit ack;
    polls = 0;
    do begin
      bus_start();
      send_byte(ctrl(1'b0), ack);
      bus_stop();
      if (!ack) polls++;
    end while (!ack && polls < 100);
  endtask

  task automatic read_seq(input int n, input string tag);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(ctrl(1'b1), ack);
    chk(ack, "R3 read control byte acknowledged", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == ref_mem[ref_ptr], tag, int'(d), int'(ref_mem[ref_ptr]));
      ref_ptr = ref_ptr + 12'd1;
    end
    bus_stop();
  endtask

  task automatic random_read(input logic [15:0] a16, input int n, input string tag);
    bit ack;
    bus_start();
    send_byte(ctrl(1'b0), ack);
    send_byte(a16[15:8], ack);
    send_byte(a16[7:0], ack);
    ref_ptr = a16[11:0];
    read_seq(n, tag);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 190000; wd++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", wd, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    bit ack, ok;
    int polls, wc0;
    logic [7:0] d;
    void'($urandom(32'd4711));
    for (int i = 0; i < MEM_N; i++) ref_mem[i] = init_val(i);
    ref_ptr = 12'h000;
    cw(5); rst_n = 1'b1; cw(5);

    chk(sda_oe == 1'b0 && wcyc_start == 1'b0 && cache_we == 1'b0,
        "R1 reset leaves bus released", int'({sda_oe, wcyc_start, cache_we}), 0);

    // R2: wrong type code, wrong select, then a match
    bus_start(); send_byte({4'b1011, SEL, 1'b0}, ack); bus_stop();
    chk(!ack, "R2 wrong type code not acknowledged", int'(ack), 0);
    bus_start(); send_byte({4'b1010, ~SEL, 1'b0}, ack); bus_stop();
    chk(!ack, "R2 wrong select not acknowledged", int'(ack), 0);
    wc0 = wc;
    bus_start(); send_byte(ctrl(1'b0), ack); bus_stop();
    chk(ack, "R2 matching control byte acknowledged", int'(ack), 1);
    cw(4);
    chk(wc == wc0, "R6 stop with no data starts no write cycle", wc - wc0, 0);

    // byte write and busy polling
    wbuf[0] = 8'h5A;
    wc0 = wc;
    do_write(16'h0123, 1, ok);
    chk(ok, "R5 byte write acknowledged", int'(ok), 1);
    cw(4);
    chk(wc == wc0 + 1, "R6 stop after data starts one write cycle", wc - wc0, 1);
    bus_start(); send_byte(ctrl(1'b1), ack); bus_stop();
    chk(!ack, "R7 read control refused while busy", int'(ack), 0);
    poll_ready(polls);
    chk(polls > 0 && polls < 100, "R7 polling refused then accepted", polls, 1);

    random_read(16'h0123, 1, "R9 random read data");
    read_seq(1, "R3 R8 current address read data");

    // address-only write then stop: pointer set, no cycle
    wc0 = wc;
    do_write(16'h0456, 0, ok);
    cw(4);
    chk(wc == wc0, "R6 address-only write starts no cycle", wc - wc0, 0);
    read_seq(2, "R8 read after address-only write");

    // burst wrap inside 64-byte window
    for (int i = 0; i < 66; i++) wbuf[i] = 8'($urandom);
    do_write(16'h007E, 66, ok);
    chk(ok, "R5 burst bytes acknowledged", int'(ok), 1);
    poll_ready(polls);
    random_read(16'h0040, 64, "R5 burst window content");
    random_read(16'h0080, 1, "R5 byte beyond window untouched");

    // upper address bits ignored
    wbuf[0] = 8'hC3;
    do_write(16'hF234, 1, ok);
    poll_ready(polls);
    random_read(16'h0234, 1, "R4 upper address bits ignored");

    // read pointer wraps at top address
    random_read(16'h0FFE, 4, "R10 sequential read across top");

    // stop after read starts no cycle
    wc0 = wc;
    read_seq(1, "R8 current read");
    cw(4);
    chk(wc == wc0, "R6 stop after read starts no cycle", wc - wc0, 0);

    // repeated start aborts a write with data
    wc0 = wc;
    wbuf[0] = 8'h77;
    bus_start(); send_byte(ctrl(1'b0), ack); send_byte(8'h03, ack); send_byte(8'h00, ack);
    send_byte(wbuf[0], ack);
    ref_mem[12'h300] = wbuf[0];
    ref_ptr = 12'h301;
    read_seq(1, "R8 read after aborted write");
    cw(4);
    chk(wc == wc0, "R6 repeated start aborts write cycle", wc - wc0, 0);

    // start and stop part way through a byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(ctrl(1'b1), ack);
    chk(ack, "R1 start mid byte restarts decode", int'(ack), 1);
    recv_byte(1'b0, d);
    chk(d == ref_mem[ref_ptr], "R1 data after restart", int'(d), int'(ref_mem[ref_ptr]));
    ref_ptr = ref_ptr + 12'd1;
    bus_stop();
    wc0 = wc;
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); bus_stop();
    bus_start(); send_byte(ctrl(1'b0), ack); bus_stop();
    chk(ack && wc == wc0, "R1 stop mid byte then fresh control", int'(ack), 1);

    // master NACK releases line and later clocks ignored
    bus_start(); send_byte(ctrl(1'b1), ack);
    recv_byte(1'b0, d);
    ref_ptr = ref_ptr + 12'd1;
    cw(6);
    chk(sda_oe == 1'b0, "R11 line released after master nack", int'(sda_oe), 0);
    send_byte(8'hFF, ack);
    chk(!ack && sda_oe == 1'b0, "R11 later clocks ignored", int'(ack), 0);
    bus_stop();

    // seeded random bursts
    for (int it = 0; it < 10; it++) begin
      logic [11:0] a;
      int n;
      a = 12'($urandom);
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write({4'h0, a}, n, ok);
      chk(ok, "R5 random burst acknowledged", int'(ok), 1);
      poll_ready(polls);
      random_read({4'h0, a}, n, "R9 R10 random burst read back");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule